// File: doc/BRIEF.md
# Two-Wire Bus Slave Bit Engine

This block is the bit-level slave of a two-wire serial bus. The master drives the clock line, and the data line is open drain. The block samples both lines with a fast system clock and passes each through a synchroniser. From the synchronised samples it finds start and stop conditions and the clock edges. It shifts received bytes in most significant bit first and shifts read bytes out the same way. On the ninth clock of each byte it either drives the acknowledge or samples the acknowledge from the master.

The core behind the engine sees each received byte as a one-cycle valid pulse, with a flag that marks the command byte. The core answers through two levels: one asks the engine to acknowledge, the other selects read direction after the acknowledged byte. Read bytes are taken from a data input, and a load pulse tells the core to present the next byte. An abort pulse reports that a start or stop ended an open transfer.

Rules for a secure memory are built in. A command byte that arrives while the nonvolatile write is busy is never acknowledged, so the master can poll the device. While the engine drives read data, or while the write is busy, it does not let a start or stop break into an open transfer.

Top module: `twi_slave_engine`

## Requirements
- R1: After reset the engine is idle and the data line is released (`sda_oe_o` low). No valid, load or abort pulse is issued until bus activity arrives.
- R2: A start condition is a falling data line while the clock line is high. A start seen in idle begins reception of a command byte, whether or not the write is busy.
- R3: Received bits are sampled on rising clock edges, most significant bit first. After the eighth bit, `rx_valid_o` pulses for one cycle with the byte on `rx_data_o`. `rx_first_o` is high only for the first byte after an accepted start. Valid, load and abort pulses never coincide.
- R4: When `ack_en_i` is high, the engine pulls the data line low through the ninth clock. When `ack_en_i` is low, it leaves the line released and goes idle, and later bytes raise no `rx_valid_o` until a new start.
- R5: A first byte received while `wr_busy_i` is high is not acknowledged, whatever the value of `ack_en_i`.
- R6: If `rd_mode_i` is high when the ninth clock of an acknowledged byte falls, the engine pulses `tx_load_o` and sends `tx_data_i` most significant bit first. A 0 bit pulls the line low and a 1 bit releases it. The output changes only while the clock line is low.
- R7: In read mode, a master acknowledge (line low on the ninth clock) loads and sends the next byte. A missing acknowledge releases the line and returns the engine to idle, so a following stop produces no abort.
- R8: A start during byte reception pulses `abort_o` and restarts reception with the next byte flagged as first.
- R9: A stop (rising data line while the clock line is high) during an open transfer pulses `abort_o` and returns the engine to idle with the line released.
- R10: While the engine is in a read transfer, start and stop conditions are ignored. No abort is raised and the byte in flight is not disturbed.
- R11: While `wr_busy_i` is high, start and stop conditions inside an open transfer are ignored. Any clock edges they contain still count as data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls the data line low; low releases it |
| wr_busy_i | input | 1 | Nonvolatile write in progress |
| ack_en_i | input | 1 | Core asks for the received byte to be acknowledged |
| rd_mode_i | input | 1 | Core selects transmit direction after the acknowledged byte |
| tx_data_i | input | BYTE_W | Next byte to transmit |
| tx_load_o | output | 1 | One-cycle pulse: `tx_data_i` was taken |
| rx_valid_o | output | 1 | One-cycle pulse: a received byte is on `rx_data_o` |
| rx_data_o | output | BYTE_W | Last received byte |
| rx_first_o | output | 1 | The byte in `rx_data_o` is the first after a start |
| abort_o | output | 1 | One-cycle pulse: a start or stop ended an open transfer |

## Verification
The bench builds the engine with 8-bit bytes and a two-stage synchroniser. A bus quarter-period is 8 system clocks, so every line change clears the synchroniser before the next bus phase. This lets the bench run a full sweep of all 256 data values through one write transfer and a 16-byte read burst with computed contents. It also places start and stop glitches inside read bytes and inside busy write bytes. In those cases the bench works out the bits that the glitch's own clock edges insert and checks the byte that results.

// File: rtl/twi_pkg.sv
package twi_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } twi_state_e;

   // Events derived from synchronised line samples, one cycle each.
   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
      logic sda;
   } twi_evt_t;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RESET_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det
   import twi_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output twi_evt_t evt
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      evt.scl_rise = scl_s & ~scl_q;
      evt.scl_fall = ~scl_s & scl_q;
      evt.start    = scl_s & scl_q & sda_q & ~sda_s;
      evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
      evt.sda      = sda_s;
   end
endmodule

// File: rtl/twi_byte_fsm.sv
module twi_byte_fsm
   import twi_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  twi_evt_t          evt,
   input  logic              wr_busy_i,
   input  logic              ack_en_i,
   input  logic              rd_mode_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   output logic              sda_oe_o,
   output logic              tx_load_o,
   output logic              rx_valid_o,
   output logic [BYTE_W-1:0] rx_data_o,
   output logic              rx_first_o,
   output logic              abort_o,
   output twi_state_e        state_o
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

   twi_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic              first;
   logic              ack_flag;
   logic              m_ack;
   logic              oe;

   logic tx_side;
   logic open_xfer;
   logic take_start;
   logic take_stop;
   logic ack_now;

   always_comb begin
      tx_side    = (state == ST_TX) || (state == ST_TX_ACK);
      open_xfer  = (state != ST_IDLE) && !wr_busy_i && !tx_side;
      take_start = evt.start && ((state == ST_IDLE) || open_xfer);
      take_stop  = evt.stop && open_xfer;
      ack_now    = ack_en_i && !(first && wr_busy_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         shreg      <= '0;
         first      <= 1'b0;
         ack_flag   <= 1'b0;
         m_ack      <= 1'b0;
         oe         <= 1'b0;
         tx_load_o  <= 1'b0;
         rx_valid_o <= 1'b0;
         rx_data_o  <= '0;
         rx_first_o <= 1'b0;
         abort_o    <= 1'b0;
      end else begin
         tx_load_o  <= 1'b0;
         rx_valid_o <= 1'b0;
         abort_o    <= 1'b0;
         if (take_start) begin
            abort_o <= (state != ST_IDLE);
            state   <= ST_RX;
            cnt     <= '0;
            first   <= 1'b1;
            oe      <= 1'b0;
         end else if (take_stop) begin
            abort_o <= 1'b1;
            state   <= ST_IDLE;
            oe      <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  oe <= 1'b0;
               end
               ST_RX: begin
                  if (evt.scl_rise && cnt != FULL) begin
                     shreg <= {shreg[BYTE_W-2:0], evt.sda};
                     cnt   <= cnt + 1'b1;
                     if (cnt == LAST_BIT) begin
                        rx_data_o  <= {shreg[BYTE_W-2:0], evt.sda};
                        rx_valid_o <= 1'b1;
                        rx_first_o <= first;
                     end
                  end else if (evt.scl_fall && cnt == FULL) begin
                     ack_flag <= ack_now;
                     oe       <= ack_now;
                     state    <= ST_RX_ACK;
                  end
               end
               ST_RX_ACK: begin
                  if (evt.scl_fall) begin
                     oe  <= 1'b0;
                     cnt <= '0;
                     if (!ack_flag) begin
                        state <= ST_IDLE;
                     end else if (rd_mode_i) begin
                        state     <= ST_TX;
                        shreg     <= tx_data_i;
                        oe        <= ~tx_data_i[BYTE_W-1];
                        tx_load_o <= 1'b1;
                     end else begin
                        state <= ST_RX;
                        first <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (evt.scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        state <= ST_TX_ACK;
                        oe    <= 1'b0;
                        m_ack <= 1'b0;
                     end else begin
                        shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        oe    <= ~shreg[BYTE_W-2];
                        cnt   <= cnt + 1'b1;
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (evt.scl_rise) begin
                     m_ack <= ~evt.sda;
                  end else if (evt.scl_fall) begin
                     cnt <= '0;
                     if (m_ack) begin
                        state     <= ST_TX;
                        shreg     <= tx_data_i;
                        oe        <= ~tx_data_i[BYTE_W-1];
                        tx_load_o <= 1'b1;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_oe_o = oe;
   assign state_o  = state;
endmodule

// File: rtl/twi_slave_engine.sv
module twi_slave_engine
   import twi_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic              wr_busy_i,
   input  logic              ack_en_i,
   input  logic              rd_mode_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   output logic              tx_load_o,
   output logic              rx_valid_o,
   output logic [BYTE_W-1:0] rx_data_o,
   output logic              rx_first_o,
   output logic              abort_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("twi_slave_engine: SYNC_STAGES must be at least 2");
      end
      if (BYTE_W < 2) begin : g_bad_width
         $error("twi_slave_engine: BYTE_W must be at least 2");
      end
   endgenerate

   logic       scl_s;
   logic       sda_s;
   twi_evt_t   evt;
   twi_state_e fsm_state;

   twi_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
   );

   twi_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
   );

   twi_cond_det u_det (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .evt(evt)
   );

   twi_byte_fsm #(.BYTE_W(BYTE_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .wr_busy_i  (wr_busy_i),
      .ack_en_i   (ack_en_i),
      .rd_mode_i  (rd_mode_i),
      .tx_data_i  (tx_data_i),
      .sda_oe_o   (sda_oe_o),
      .tx_load_o  (tx_load_o),
      .rx_valid_o (rx_valid_o),
      .rx_data_o  (rx_data_o),
      .rx_first_o (rx_first_o),
      .abort_o    (abort_o),
      .state_o    (fsm_state)
   );
endmodule

// File: rtl/twi_slave_engine_chk.sv
module twi_slave_engine_chk
   import twi_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input twi_state_e state,
   input logic       scl_s,
   input logic       sda_oe_o,
   input logic       wr_busy_i,
   input logic       rx_valid_o,
   input logic       rx_first_o,
   input logic       tx_load_o,
   input logic       abort_o
);
   // R1: idle never pulls the line
   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE |-> !sda_oe_o);

   // R3: handshake pulses are mutually exclusive
   p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_valid_o, tx_load_o, abort_o}));

   // R5: command byte received during a busy write is refused
   p_busy_first_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RX_ACK && $past(state) != ST_RX_ACK && rx_first_o && $past(wr_busy_i))
      |-> !sda_oe_o);

   // R6: transmitted data holds while the clock line is high
   p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX && $past(state) == ST_TX && scl_s && $past(scl_s))
      |-> $stable(sda_oe_o));

   // R10: no abort out of a read transfer
   p_tx_no_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> !($past(state) == ST_TX || $past(state) == ST_TX_ACK));

   // R11: no abort while the write is busy
   p_busy_no_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> !$past(wr_busy_i));
endmodule

bind twi_slave_engine twi_slave_engine_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .state      (fsm_state),
   .scl_s      (scl_s),
   .sda_oe_o   (sda_oe_o),
   .wr_busy_i  (wr_busy_i),
   .rx_valid_o (rx_valid_o),
   .rx_first_o (rx_first_o),
   .tx_load_o  (tx_load_o),
   .abort_o    (abort_o)
);

// File: tb/twi_slave_engine_bench.sv
module twi_slave_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;
   localparam int WATCHDOG   = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic       wr_busy = 1'b0;
   logic       ack_en = 1'b1;
   logic       rd_mode = 1'b0;
   logic [7:0] tx_data;
   logic       tx_load;
   logic       rx_valid;
   logic [7:0] rx_data;
   logic       rx_first;
   logic       abort;
   logic       sda_bus;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int rx_cnt = 0;
   int ld_cnt = 0;
   int ab_cnt = 0;
   logic [7:0] rx_last = 8'h00;
   logic       rx_first_last = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   function automatic logic [7:0] pat(input int k);
      return 8'((k * 37 + 5) & 8'hFF);
   endfunction

   assign tx_data = pat(ld_cnt);

   twi_slave_engine u_twi_slave_engine (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
      .wr_busy_i(wr_busy), .ack_en_i(ack_en), .rd_mode_i(rd_mode),
      .tx_data_i(tx_data), .tx_load_o(tx_load), .rx_valid_o(rx_valid),
      .rx_data_o(rx_data), .rx_first_o(rx_first), .abort_o(abort)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (tx_load) ld_cnt <= ld_cnt + 1;
      if (abort)   ab_cnt <= ab_cnt + 1;
      if (rx_valid) begin
         rx_cnt        <= rx_cnt + 1;
         rx_last       <= rx_data;
         rx_first_last <= rx_first;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq;
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wq;
      scl = 1'b1;   wq;
      sda_m = 1'b0; wq;
      scl = 1'b0;   wq;
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wq;
      scl = 1'b1;   wq;
      sda_m = 1'b1; wq;
   endtask

   task automatic put_bit(input logic b);
      sda_m = b;  wq;
      scl = 1'b1; wq; wq;
      scl = 1'b0; wq;
   endtask

   task automatic write_byte(input logic [7:0] v, output logic acked);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      sda_m = 1'b1; wq;
      scl = 1'b1;   wq;
      acked = ~sda_bus;
      wq;
      scl = 1'b0;   wq;
   endtask

   task automatic read_byte(input bit glitch, input bit mack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wq;
         scl = 1'b1;   wq;
         d[i] = sda_bus;
         if (glitch) sda_m = 1'b0;
         wq;
         sda_m = 1'b1;
         wq;
         scl = 1'b0;   wq;
      end
      sda_m = ~mack; wq;
      scl = 1'b1;    wq; wq;
      scl = 1'b0;    wq;
      sda_m = 1'b1;
   endtask

   initial begin
      wait (cycles >= WATCHDOG);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic       ak;
      logic [7:0] d;
      int         c0;
      int         a0;
      int         base;

      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      wq;
      // R1: reset state
      check(sda_oe == 1'b0, "R1 line released", int'(sda_oe), 0);
      check(rx_cnt == 0 && ab_cnt == 0 && ld_cnt == 0, "R1 no pulses", rx_cnt + ab_cnt + ld_cnt, 0);

      // R2 R3 R4: write sweep of every data value
      bus_start;
      write_byte(8'hA5, ak);
      check(ak == 1'b1, "R4 command acked", int'(ak), 1);
      check(rx_last == 8'hA5 && rx_first_last, "R2 R3 command byte", int'({rx_first_last, rx_last}), 'h1A5);
      for (int v = 0; v < 256; v++) begin
         write_byte(8'(v), ak);
         check(ak == 1'b1, "R4 data acked", int'(ak), 1);
         check(rx_last == 8'(v), "R3 data byte", int'(rx_last), v);
         check(rx_first_last == 1'b0, "R3 first flag clear", int'(rx_first_last), 0);
      end
      a0 = ab_cnt;
      bus_stop;
      wq;
      check(ab_cnt == a0 + 1, "R9 stop aborts", ab_cnt, a0 + 1);
      check(sda_oe == 1'b0, "R9 released after stop", int'(sda_oe), 0);

      // R4: refusal when ack disabled, later bytes ignored
      ack_en = 1'b0;
      bus_start;
      write_byte(8'h3C, ak);
      check(ak == 1'b0, "R4 no ack when disabled", int'(ak), 0);
      c0 = rx_cnt;
      write_byte(8'h11, ak);
      check(rx_cnt == c0, "R4 byte after refusal ignored", rx_cnt, c0);
      check(ak == 1'b0, "R4 line left released", int'(ak), 0);
      ack_en = 1'b1;
      bus_stop;

      // R5: acknowledge polling during busy write
      wr_busy = 1'b1;
      bus_start;
      write_byte(8'h5A, ak);
      check(ak == 1'b0, "R5 busy command refused", int'(ak), 0);
      check(rx_first_last == 1'b1 && rx_last == 8'h5A, "R2 start accepted while busy",
            int'({rx_first_last, rx_last}), 'h15A);
      bus_stop;
      wr_busy = 1'b0;
      bus_start;
      write_byte(8'h5A, ak);
      check(ak == 1'b1, "R5 command acked when ready", int'(ak), 1);
      bus_stop;

      // R6 R7: read burst
      rd_mode = 1'b1;
      bus_start;
      write_byte(8'h81, ak);
      check(ak == 1'b1, "R6 read command acked", int'(ak), 1);
      base = ld_cnt - 1;
      for (int k = 0; k < 16; k++) begin
         read_byte(1'b0, k != 15, d);
         check(d == pat(base + k), "R6 read byte", int'(d), int'(pat(base + k)));
      end
      check(ld_cnt == base + 16, "R7 loads follow master ack", ld_cnt - base, 16);
      check(sda_oe == 1'b0, "R7 released after master nack", int'(sda_oe), 0);
      a0 = ab_cnt;
      bus_stop;
      wq;
      check(ab_cnt == a0, "R7 idle after master nack", ab_cnt, a0);

      // R10: start/stop glitches inside read bytes are ignored
      bus_start;
      write_byte(8'h81, ak);
      base = ld_cnt - 1;
      a0 = ab_cnt;
      read_byte(1'b0, 1'b1, d);
      check(d == pat(base), "R10 byte before glitch", int'(d), int'(pat(base)));
      read_byte(1'b1, 1'b1, d);
      check(d == pat(base + 1), "R10 glitched byte intact", int'(d), int'(pat(base + 1)));
      read_byte(1'b0, 1'b0, d);
      check(d == pat(base + 2), "R10 byte after glitch", int'(d), int'(pat(base + 2)));
      check(ab_cnt == a0, "R10 no abort while sending", ab_cnt, a0);
      bus_stop;
      rd_mode = 1'b0;

      // R11: start and stop inside a busy write transfer are ignored
      bus_start;
      write_byte(8'h40, ak);
      wr_busy = 1'b1;
      a0 = ab_cnt;
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      bus_start;                        // its clock rise adds a 1 bit
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
      sda_m = 1'b1; wq; scl = 1'b1; wq; ak = ~sda_bus; wq; scl = 1'b0; wq;
      check(rx_last == 8'hAB, "R11 start ignored while busy", int'(rx_last), 'hAB);
      check(rx_first_last == 1'b0 && ak == 1'b1, "R11 transfer continues",
            int'({rx_first_last, ak}), 1);
      bus_stop;                         // its clock rise adds a 0 bit
      scl = 1'b0; wq;
      for (int i = 6; i >= 0; i--) put_bit(logic'((8'h77 >> i) & 1));
      sda_m = 1'b1; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
      check(rx_last == 8'h77, "R11 stop ignored while busy", int'(rx_last), 'h77);
      check(ab_cnt == a0, "R11 no abort while busy", ab_cnt, a0);
      wr_busy = 1'b0;
      bus_stop;
      wq;
      check(ab_cnt == a0 + 1, "R9 stop aborts once ready", ab_cnt, a0 + 1);

      // R8: start during reception restarts
      bus_start;
      write_byte(8'h22, ak);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      a0 = ab_cnt;
      bus_start;
      check(ab_cnt == a0 + 1, "R8 start aborts", ab_cnt, a0 + 1);
      write_byte(8'h99, ak);
      check(rx_last == 8'h99 && rx_first_last, "R8 restart first byte",
            int'({rx_first_last, rx_last}), 'h199);
      check(ak == 1'b1, "R8 restarted command acked", int'(ak), 1);
      bus_stop;
      wq;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule